// File: doc/BRIEF.md
# Multiplexed Bus Cycle Sequencer

This block is the processor-side end of a shared multiplexed bus. It connects a 16-bit core with a 20-bit address space to a bus whose low sixteen lines carry first the address and then the data. The four lines above them carry first the top address bits and then status. The core presents one transfer at a time: address, direction, memory or I/O space, byte or word size, and write data. The sequencer then steps through the address, strobe, optional wait, data and recovery phases. At the end it raises a one-clock completion pulse together with the returned read data.

The sequencer has six states. `ST_IDLE` waits for a request. `ST_T1` is the address phase with the latch strobe high. `ST_T2` opens the strobe. `ST_TW` is a wait state, entered and held while the target holds `ready` low. `ST_T3` is the data phase, where read data is captured. `ST_T4` is recovery with the done pulse. The transitions are:
- IDLE→T1 on an accepted request.
- T1→T2 always.
- T2→T3 when `ready` is high at the closing clock edge of T2.
- T2→TW when `ready` is low at that edge.
- TW→TW while `ready` stays low.
- TW→T3 once `ready` is high.
- T3→T4 always.
- T4→IDLE always.

Top module: `mbus_seq`

## Requirements
- R1: A request is taken only when `req_valid` is high in ST_IDLE. A request raised in any other state starts no cycle: `ale` produces exactly one pulse per accepted transfer.
- R2: In ST_T1, `ale` is high for exactly one clock. `ad_out` drives address bits 15..0 with `ad_oe` high, and `as_out` drives address bits 19..16.
- R3: In ST_T1, `bhe_n` is 0 for a word or an odd-address byte, and 1 for an even-address byte. Together with address bit 0 this gives 00 word, 01 high byte, 10 low byte. Word requests must use an even address.
- R4: From ST_T2 to ST_T4, `as_out` carries the status code (default 4'b0000) and `bhe_n` is held at 1.
- R5: `ready` is sampled at the clock edge that closes ST_T2 and at each edge that closes ST_TW. The strobe is therefore low for exactly 2 + N clocks, where N is the number of those samples that found `ready` low.
- R6: `rd_n` (reads) or `wr_n` (writes) is low from ST_T2 through ST_T3, including every ST_TW, and high in ST_T4. The two are never low together.
- R7: `dt_r` is 0 for a read and 1 for a write, held steady from ST_T1 to ST_T4. `m_io` is 1 for memory and 0 for I/O over the same span.
- R8: `den_n` is low exactly in ST_T2, ST_TW and ST_T3.
- R9: On a write, `ad_out` carries data from ST_T2 to ST_T4 with `ad_oe` high. A word goes out as is. An odd-address byte goes out on bits 15..8 with 0 on bits 7..0. An even-address byte goes out on bits 7..0 with 0 on bits 15..8. The byte is taken from `req_wdata[7:0]`. On a read, `ad_oe` is low after ST_T1.
- R10: On a read, `ad_in` is captured at the edge closing ST_T3. A word is returned as is. A byte is returned in bits 7..0, zero-extended, taken from bits 15..8 for an odd address and from bits 7..0 for an even address.
- R11: `done` is high for exactly the one clock of ST_T4, with `rd_data` valid. The next clock is ST_IDLE with `idle` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Transfer request |
| req_addr | input | 20 | Transfer address |
| req_write | input | 1 | 1 write, 0 read |
| req_mem | input | 1 | 1 memory space, 0 I/O space |
| req_word | input | 1 | 1 word, 0 byte |
| req_wdata | input | 16 | Write data (byte in bits 7..0) |
| ready | input | 1 | Target ready, low inserts wait states |
| ad_in | input | 16 | Sampled level of the shared address/data lines |
| ad_out | output | 16 | Value driven onto the shared lines |
| ad_oe | output | 1 | Drive enable for the shared lines |
| as_out | output | 4 | Upper address bits, then status |
| ale | output | 1 | Address latch strobe |
| bhe_n | output | 1 | High-byte enable (active low), then constant 1 |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| m_io | output | 1 | Memory (1) or I/O (0) cycle |
| dt_r | output | 1 | Transceiver direction, 1 transmit |
| den_n | output | 1 | Transceiver enable, active low |
| rd_data | output | 16 | Returned read data |
| done | output | 1 | One-clock completion pulse |
| idle | output | 1 | Sequencer in ST_IDLE |

## Verification
The bench runs transfers with 0, 1, 2 and 3 wait states. A design that samples `ready` one edge late, or not in T2, shows a strobe width other than 2 + N. Odd and even byte transfers are run in both directions. A design that swaps lanes, or that fails to right-justify an upper-lane byte, shows the wrong lane data on the bus or a wrong `rd_data`. One transfer has a second request pulsed in mid-cycle; a sequencer that accepts outside idle produces an extra `ale` pulse. After each completion the bench checks that `done` has fallen and the block is idle, which catches a stretched done pulse or a missed return to idle.

// File: rtl/mbus_pkg.sv
package mbus_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_T1,
        ST_T2,
        ST_TW,
        ST_T3,
        ST_T4
    } bstate_t;

endpackage

// File: rtl/mbus_fsm.sv
module mbus_fsm
    import mbus_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    req_valid,
    input  logic    ready,
    output bstate_t state,
    output logic    accept
);

    bstate_t state_nx;

    assign accept = req_valid && (state == ST_IDLE);

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (req_valid) state_nx = ST_T1;
            ST_T1:   state_nx = ST_T2;
            ST_T2:   state_nx = ready ? ST_T3 : ST_TW;
            ST_TW:   state_nx = ready ? ST_T3 : ST_TW;
            ST_T3:   state_nx = ST_T4;
            ST_T4:   state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    assert_busy_no_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE && req_valid) |=> state != ST_T1);

    assert_wait_on_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_T2 || state == ST_TW) && !ready) |=> state == ST_TW);

    assert_leave_wait_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_T2 || state == ST_TW) && ready) |=> state == ST_T3);

endmodule

// File: rtl/mbus_lane.sv
module mbus_lane #(
    parameter int DATA_W = 16,
    parameter int LANE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              word,
    input  logic              a0,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] ad_in,
    input  logic              capture,
    output logic [DATA_W-1:0] wr_lanes,
    output logic [DATA_W-1:0] rd_data
);

    localparam int NUM_LANES = DATA_W / LANE_W;

    logic [NUM_LANES-1:0] lane_en;
    logic [LANE_W-1:0]    rd_byte;
    logic [DATA_W-1:0]    rd_next;

    for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
        assign lane_en[l] = word || ((l == 1) ? a0 : !a0);
        assign wr_lanes[l*LANE_W +: LANE_W] =
            !lane_en[l] ? '0 :
            (word ? wdata[l*LANE_W +: LANE_W] : wdata[LANE_W-1:0]);
    end

    assign rd_byte = ad_in[(a0 ? LANE_W : 0) +: LANE_W];
    assign rd_next = word ? ad_in : DATA_W'(rd_byte);

    always_ff @(posedge clk) begin
        if (!rst_n)       rd_data <= '0;
        else if (capture) rd_data <= rd_next;
    end

    assert_byte_single_lane_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !word |-> $countones(lane_en) == 1);

    assert_rd_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !capture |=> $stable(rd_data));

endmodule

// File: rtl/mbus_seq.sv
module mbus_seq
    import mbus_pkg::*;
#(
    parameter int ADDR_W      = 20,
    parameter int DATA_W      = 16,
    parameter int STATUS_CODE = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_write,
    input  logic              req_mem,
    input  logic              req_word,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              ready,
    input  logic [DATA_W-1:0] ad_in,
    output logic [DATA_W-1:0] ad_out,
    output logic              ad_oe,
    output logic [ADDR_W-DATA_W-1:0] as_out,
    output logic              ale,
    output logic              bhe_n,
    output logic              rd_n,
    output logic              wr_n,
    output logic              m_io,
    output logic              dt_r,
    output logic              den_n,
    output logic [DATA_W-1:0] rd_data,
    output logic              done,
    output logic              idle
);

    localparam int HI_W = ADDR_W - DATA_W;
    localparam logic [HI_W-1:0] STATUS = HI_W'(STATUS_CODE);

    bstate_t           state;
    logic              accept;
    logic [ADDR_W-1:0] r_addr;
    logic              r_write, r_mem, r_word;
    logic [DATA_W-1:0] r_wdata;
    logic [DATA_W-1:0] wr_lanes;

    mbus_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .ready     (ready),
        .state     (state),
        .accept    (accept)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_addr  <= '0;
            r_write <= 1'b0;
            r_mem   <= 1'b0;
            r_word  <= 1'b0;
            r_wdata <= '0;
        end else if (accept) begin
            r_addr  <= req_addr;
            r_write <= req_write;
            r_mem   <= req_mem;
            r_word  <= req_word;
            r_wdata <= req_wdata;
        end
    end

    mbus_lane #(.DATA_W(DATA_W), .LANE_W(8)) u_lane (
        .clk      (clk),
        .rst_n    (rst_n),
        .word     (r_word),
        .a0       (r_addr[0]),
        .wdata    (r_wdata),
        .ad_in    (ad_in),
        .capture  (state == ST_T3),
        .wr_lanes (wr_lanes),
        .rd_data  (rd_data)
    );

    always_comb begin
        ale    = 1'b0;
        ad_out = '0;
        ad_oe  = 1'b0;
        as_out = '0;
        bhe_n  = 1'b1;
        rd_n   = 1'b1;
        wr_n   = 1'b1;
        m_io   = 1'b0;
        dt_r   = 1'b1;
        den_n  = 1'b1;
        done   = 1'b0;
        idle   = 1'b0;
        unique case (state)
            ST_IDLE: idle = 1'b1;
            ST_T1: begin
                ale    = 1'b1;
                ad_out = r_addr[DATA_W-1:0];
                ad_oe  = 1'b1;
                as_out = r_addr[ADDR_W-1:DATA_W];
                bhe_n  = !(r_word || r_addr[0]);
                m_io   = r_mem;
                dt_r   = r_write;
            end
            ST_T2, ST_TW, ST_T3: begin
                as_out = STATUS;
                m_io   = r_mem;
                dt_r   = r_write;
                den_n  = 1'b0;
                rd_n   = r_write;
                wr_n   = !r_write;
                ad_out = r_write ? wr_lanes : '0;
                ad_oe  = r_write;
            end
            ST_T4: begin
                as_out = STATUS;
                m_io   = r_mem;
                dt_r   = r_write;
                ad_out = r_write ? wr_lanes : '0;
                ad_oe  = r_write;
                done   = 1'b1;
            end
            default: idle = 1'b0;
        endcase
    end

    assert_ale_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ale |=> !ale);

    assert_strobe_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(!rd_n && !wr_n));

    assert_den_covers_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_n || !wr_n) |-> !den_n);

    assert_dir_steady_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_T2 || state == ST_TW || state == ST_T3 || state == ST_T4)
        |-> $stable(dt_r));

    assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && idle));

endmodule

// File: tb/tb_mbus_seq.sv
module tb_mbus_seq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [19:0] req_addr = '0;
    logic        req_write = 1'b0, req_mem = 1'b0, req_word = 1'b0;
    logic [15:0] req_wdata = '0;
    logic        ready = 1'b1;
    logic [15:0] ad_in = '0;
    logic [15:0] ad_out, rd_data;
    logic [3:0]  as_out;
    logic        ad_oe, ale, bhe_n, rd_n, wr_n, m_io, dt_r, den_n, done, idle;

    always #10 clk = ~clk;

    mbus_seq dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_write(req_write), .req_mem(req_mem), .req_word(req_word),
        .req_wdata(req_wdata), .ready(ready), .ad_in(ad_in), .ad_out(ad_out),
        .ad_oe(ad_oe), .as_out(as_out), .ale(ale), .bhe_n(bhe_n), .rd_n(rd_n),
        .wr_n(wr_n), .m_io(m_io), .dt_r(dt_r), .den_n(den_n),
        .rd_data(rd_data), .done(done), .idle(idle)
    );

    typedef struct {
        logic [19:0] addr;
        logic        write;
        logic        mem;
        logic        bhe_n;
        logic [15:0] lanes;
        logic [15:0] rdata;
        int          waits;
    } exp_t;

    exp_t exp_q[$];
    int   n_checks = 0, n_fails = 0;
    int   wait_cfg = 0;
    int   since_ale = 0;
    int   strobes = 0;
    int   ale_seen = 0, accepted = 0;
    bit   after_done = 0;
    bit   finished = 0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // monitor: pops expected items and compares what the bus shows
    always @(negedge clk) begin
        if (rst_n) begin
            if (ale) since_ale = 0; else since_ale++;
            ready = (since_ale > wait_cfg);
            if (after_done) begin
                chk(!done && idle, "R11 done single clock then idle", {done, idle}, 2'b01);
                after_done = 0;
            end
            if (ale && exp_q.size() != 0) begin
                ale_seen++;
                strobes = 0;
                chk(ad_oe && ad_out == exp_q[0].addr[15:0], "R2 address on low lines",
                    ad_out, exp_q[0].addr[15:0]);
                chk(as_out == exp_q[0].addr[19:16], "R2 upper address", as_out,
                    exp_q[0].addr[19:16]);
                chk(bhe_n == exp_q[0].bhe_n, "R3 byte enable", bhe_n, exp_q[0].bhe_n);
                chk(dt_r == exp_q[0].write && m_io == exp_q[0].mem, "R7 dir/space in T1",
                    {dt_r, m_io}, {exp_q[0].write, exp_q[0].mem});
            end else if (ale) begin
                ale_seen++;
            end
            if ((!rd_n || !wr_n) && exp_q.size() != 0) begin
                strobes++;
                chk(exp_q[0].write ? (!wr_n && rd_n) : (!rd_n && wr_n), "R6 strobe select",
                    {rd_n, wr_n}, exp_q[0].write ? 2'b10 : 2'b01);
                chk(!den_n, "R8 den in data phase", den_n, 0);
                chk(bhe_n && as_out == 4'h0, "R4 status phase", {bhe_n, as_out}, 5'h10);
                chk(dt_r == exp_q[0].write && m_io == exp_q[0].mem, "R7 dir/space held",
                    {dt_r, m_io}, {exp_q[0].write, exp_q[0].mem});
                if (exp_q[0].write)
                    chk(ad_oe && ad_out == exp_q[0].lanes, "R9 write lanes", ad_out,
                        exp_q[0].lanes);
                else
                    chk(!ad_oe, "R9 read releases lines", ad_oe, 0);
            end
            if (done && exp_q.size() != 0) begin
                chk(strobes == exp_q[0].waits + 2, "R5 strobe width", strobes,
                    exp_q[0].waits + 2);
                chk(rd_n && wr_n && den_n, "R6 R8 released in T4", {rd_n, wr_n, den_n}, 3'b111);
                if (exp_q[0].write)
                    chk(ad_oe && ad_out == exp_q[0].lanes, "R9 write data in T4", ad_out,
                        exp_q[0].lanes);
                else
                    chk(rd_data == exp_q[0].rdata, "R10 read data", rd_data,
                        exp_q[0].rdata);
                void'(exp_q.pop_front());
                after_done = 1;
            end
        end
    end

    task automatic xfer(input logic [19:0] addr, input bit write, input bit mem,
                        input bit word, input logic [15:0] wdata,
                        input logic [15:0] bus, input int waits, input bit poke);
        exp_t e;
        e.addr  = addr;
        e.write = write;
        e.mem   = mem;
        e.bhe_n = !(word || addr[0]);
        e.waits = waits;
        e.lanes = word ? wdata : (addr[0] ? {wdata[7:0], 8'h00} : {8'h00, wdata[7:0]});
        e.rdata = word ? bus : (addr[0] ? {8'h00, bus[15:8]} : {8'h00, bus[7:0]});
        @(negedge clk);
        while (!idle) @(negedge clk);
        exp_q.push_back(e);
        wait_cfg  = waits;
        ad_in     = bus;
        req_addr  = addr;
        req_write = write;
        req_mem   = mem;
        req_word  = word;
        req_wdata = wdata;
        req_valid = 1'b1;
        accepted++;
        @(negedge clk);
        req_valid = 1'b0;
        if (poke) begin
            // R1: a request raised mid-cycle must not start another cycle
            @(negedge clk);
            req_addr  = 20'h12345;
            req_valid = 1'b1;
            @(negedge clk);
            req_valid = 1'b0;
        end
        while (exp_q.size() != 0) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(idle && !ale && rd_n && wr_n && den_n && !ad_oe && !done && bhe_n,
            "R11 reset state", {idle, ale, rd_n, wr_n, den_n, ad_oe, done, bhe_n},
            8'b10111001);
        rst_n = 1'b1;
        xfer(20'h3A4B6, 0, 1, 1, 16'h0000, 16'hBEEF, 0, 0);
        xfer(20'h00201, 1, 0, 0, 16'h00C3, 16'h0000, 1, 0);
        xfer(20'hF1235, 0, 1, 0, 16'h0000, 16'hA55A, 3, 0);
        xfer(20'h54320, 0, 0, 0, 16'h0000, 16'h1E2D, 0, 0);
        xfer(20'h80010, 1, 1, 1, 16'h9876, 16'h0000, 2, 1);
        xfer(20'h0FFFE, 1, 1, 0, 16'h005A, 16'h0000, 0, 0);
        xfer(20'hFFFFE, 0, 1, 1, 16'h0000, 16'h7FF1, 1, 1);
        xfer(20'h6789B, 0, 0, 0, 16'h0000, 16'hC4F0, 2, 0);
        repeat (4) @(negedge clk);
        chk(ale_seen == accepted, "R1 one ale per accepted request", ale_seen, accepted);
        chk(idle && !done, "R1 R11 stays idle", {idle, done}, 2'b10);
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog R11 actual=hung expected=complete");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

endmodule